// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block is the single 32-bit interrupt control and status word shared by the seven channels of a DMA controller. Software programs per-channel enables, a global enable and a force bit through plain register writes, and reads back one completion flag per channel together with a summary bit that says an interrupt is owed. Completion pulses from the transfer engines latch their flags, and software acknowledges a flag by writing a one to it.

Whenever the summary bit moves from clear to set, the block emits a single-cycle request toward the system interrupt controller. The summary bit cannot be written; it is recomputed from the other fields on every clock, so a write that removes every cause drops it, and a later cause raises a fresh request.

Top module: `dma_irq_status_reg`

## Requirements
- R1: After reset the whole register reads zero and irqPulse is low.
- R2: A write loads bits 0 to 5 (free control field), bit 15 (force), bits 16 to 22 (channel enables, bit 16+i for channel i) and bit 23 (global enable) from the written word; bits 6 to 14 always read zero whatever was written.
- R3: Bits 24 to 30 hold the completion flags, bit 24+i for channel i. A write with a one in bit 24+i clears that flag, a zero leaves it unchanged; the written value of bit 31 is ignored.
- R4: chanDone[i] high on a clock edge sets flag 24+i only when enable bit 16+i was set before that edge; if the same edge also carries a clearing write for that flag, the flag ends set.
- R5: Bit 31 (summary) reads one in the cycle after any edge that leaves the global enable set together with at least one completion flag.
- R6: Bit 31 reads one whenever bit 15 (force) is set, regardless of the enables and flags.
- R7: When an update leaves neither the force bit nor the global-enable-with-flag condition true, bit 31 reads zero, even if it was one before.
- R8: irqPulse is high for exactly the one cycle in which bit 31 first reads one after reading zero, and stays low while bit 31 remains one.
- R9: With no write and no completion input, the register value does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 32 | Value written when wrEn is high |
| chanDone | input | 7 | Per-channel completion strobes, bit i for channel i |
| rdData | output | 32 | Current register value |
| irqPulse | output | 1 | Single-cycle request to the system interrupt controller |

## Verification
A wrong flag or enable bit shows on rdData one cycle after the edge that produced it, and a wrong summary bit shows on bit 31 at the same time, so every stimulus step is checked against an arithmetic model of the word on the following cycle. A lost or duplicated request shows on irqPulse in that same cycle, because the pulse and the summary bit are registered on the same edge. The sweeps cover every enable pattern against every completion pattern, every acknowledge pattern against a full set of flags, and every value of the free field with junk in the reserved bits.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Field layout of the status word; positions follow from the channel count.
  localparam int DMA_CH     = 7;
  localparam int LOW_W      = 6;
  localparam int FORCE_POS  = 15;
  localparam int EN_LO      = FORCE_POS + 1;
  localparam int GBL_POS    = EN_LO + DMA_CH;
  localparam int FLAG_LO    = GBL_POS + 1;
  localparam int MASTER_POS = FLAG_LO + DMA_CH;
  localparam int REG_W      = MASTER_POS + 1;
  localparam int RSV_W      = FORCE_POS - LOW_W;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic              cfgLoad;
    logic [DMA_CH-1:0] flagSet;
    logic [DMA_CH-1:0] flagClr;
  } irqStrobes_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = DMA_CH
) (
  input  logic              wrEn,
  input  logic [NUM_CH-1:0] wrFlags,
  input  logic [NUM_CH-1:0] chanDone,
  input  logic [NUM_CH-1:0] chEnCur,
  output irqStrobes_t       strobes
);
  // A write loads the configuration fields in one go.
  assign strobes.cfgLoad = wrEn;

  // Per channel: gated completion sets, written ones clear.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign strobes.flagSet[i] = chanDone[i] & chEnCur[i];
    assign strobes.flagClr[i] = wrEn & wrFlags[i];
  end
endmodule

// File: rtl/dma_irq_dp.sv
module dma_irq_dp
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = DMA_CH,
  parameter int LOWW   = LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [LOWW-1:0]   lowIn,
  input  logic              forceIn,
  input  logic [NUM_CH-1:0] enIn,
  input  logic              gblIn,
  output logic [NUM_CH-1:0] chEnOut,
  output logic [REG_W-1:0]  regOut,
  output logic              irqPulse
);
  logic [LOWW-1:0]   lowQ;
  logic              forceQ;
  logic [NUM_CH-1:0] chEnQ;
  logic              gblQ;
  logic [NUM_CH-1:0] flagsQ;
  logic              masterQ;

  logic [LOWW-1:0]   lowNext;
  logic              forceNext;
  logic [NUM_CH-1:0] chEnNext;
  logic              gblNext;
  logic [NUM_CH-1:0] flagsNext;
  logic              masterNext;

  always_comb begin
    lowNext   = lowQ;
    forceNext = forceQ;
    chEnNext  = chEnQ;
    gblNext   = gblQ;
    if (strobes.cfgLoad) begin
      lowNext   = lowIn;
      forceNext = forceIn;
      chEnNext  = enIn;
      gblNext   = gblIn;
    end
    // Set has priority over a same-edge acknowledge.
    flagsNext  = (flagsQ & ~strobes.flagClr) | strobes.flagSet;
    masterNext = forceNext | (gblNext & (|flagsNext));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ     <= '0;
      forceQ   <= 1'b0;
      chEnQ    <= '0;
      gblQ     <= 1'b0;
      flagsQ   <= '0;
      masterQ  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      lowQ     <= lowNext;
      forceQ   <= forceNext;
      chEnQ    <= chEnNext;
      gblQ     <= gblNext;
      flagsQ   <= flagsNext;
      masterQ  <= masterNext;
      irqPulse <= masterNext & ~masterQ;
    end
  end

  assign chEnOut = chEnQ;
  assign regOut  = {masterQ, flagsQ, gblQ, chEnQ, forceQ, {RSV_W{1'b0}}, lowQ};
endmodule

// File: rtl/dma_irq_status_reg.sv
module dma_irq_status_reg
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic [DMA_CH-1:0] chanDone,
  output logic [REG_W-1:0]  rdData,
  output logic              irqPulse
);
  irqStrobes_t       strobes;
  logic [DMA_CH-1:0] chEnCur;
  logic              unusedWrBits;

  assign unusedWrBits = ^{wrData[MASTER_POS], wrData[FORCE_POS-1:LOW_W]};

  dma_irq_ctrl #(.NUM_CH(DMA_CH)) u_ctrl (
    .wrEn     (wrEn),
    .wrFlags  (wrData[MASTER_POS-1:FLAG_LO]),
    .chanDone (chanDone),
    .chEnCur  (chEnCur),
    .strobes  (strobes)
  );

  dma_irq_dp #(.NUM_CH(DMA_CH), .LOWW(LOW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .lowIn    (wrData[LOW_W-1:0]),
    .forceIn  (wrData[FORCE_POS]),
    .enIn     (wrData[GBL_POS-1:EN_LO]),
    .gblIn    (wrData[GBL_POS]),
    .chEnOut  (chEnCur),
    .regOut   (rdData),
    .irqPulse (irqPulse)
  );
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk
  import dma_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DMA_CH-1:0] chanDone,
  input logic [REG_W-1:0]  rdData,
  input logic              irqPulse
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[FORCE_POS-1:LOW_W] == '0); // R2

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((rdData[MASTER_POS-1:FLAG_LO] & ~$past(rdData[MASTER_POS-1:FLAG_LO]))
               & ~$past(rdData[GBL_POS-1:EN_LO] & chanDone)) == '0); // R4

  AST_FORCE_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    rdData[FORCE_POS] |-> rdData[MASTER_POS]); // R6

  AST_MASTER_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rdData[MASTER_POS] |-> (rdData[FORCE_POS] ||
      (rdData[GBL_POS] && (|rdData[MASTER_POS-1:FLAG_LO])))); // R7

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[MASTER_POS]) |-> irqPulse); // R8

  AST_PULSE_ONLY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $rose(rdData[MASTER_POS])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && chanDone == '0) |=> $stable(rdData)); // R9
endmodule

bind dma_irq_status_reg dma_irq_chk u_chk (.*);

// File: tb/tb_dma_irq_status_reg.sv
`timescale 1ns/1ps
module tb_dma_irq_status_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  chanDone = '0;
  logic [31:0] rdData;
  logic        irqPulse;

  int checks = 0;
  int fails = 0;
  logic [31:0] model = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_irq_status_reg dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .chanDone(chanDone), .rdData(rdData), .irqPulse(irqPulse)
  );

  function automatic logic [31:0] nextModel(logic [31:0] old, bit wr, logic [31:0] d,
                                            logic [6:0] done);
    logic [6:0]  flags;
    logic [31:0] r;
    flags = old[30:24];
    if (wr) flags = flags & ~d[30:24];
    flags = flags | (done & old[22:16]);
    r = (wr ? d : old) & 32'h00FF803F;
    r = r | ({25'd0, flags} << 24);
    if (r[15] || (r[23] && flags != 0)) r[31] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] expR, bit expP);
    checks++;
    if (rdData !== expR || irqPulse !== expP) begin
      fails++;
      $display("FAIL %s: rdData=%h irqPulse=%0b expected rdData=%h irqPulse=%0b",
               tag, rdData, irqPulse, expR, expP);
    end
  endtask

  // Drive one cycle of stimulus, then check the registered result.
  task automatic step(string tag, bit wr, logic [31:0] d, logic [6:0] done);
    logic [31:0] nm;
    bit pulse;
    wrEn = wr; wrData = d; chanDone = done;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; chanDone = '0;
    nm = nextModel(model, wr, d, done);
    pulse = nm[31] && !model[31];
    model = nm;
    check(tag, model, pulse);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);

    // R2: free field sweep with junk in reserved bits
    for (int v = 0; v < 64; v++) step("R2", 1, 32'h00007FC0 | v, 7'h0);

    // R3: bus cannot set flags or the summary bit
    step("R3", 1, 32'hFF800000, 7'h0);
    step("R3", 1, 32'h0, 7'h0);

    // R6/R8/R7: force bit raises, holds without a new pulse, then drops
    step("R6", 1, 32'h00008000, 7'h0);
    step("R8", 0, 32'h0, 7'h0);
    step("R9", 0, 32'h0, 7'h0);
    step("R7", 1, 32'h0, 7'h0);

    // R4/R5: every enable pattern against every completion pattern
    for (int e = 0; e < 128; e++) begin
      for (int dn = 0; dn < 128; dn++) begin
        step("R5", 1, 32'h7F800000 | (e << 16), 7'h0);
        step("R4", 0, 32'h0, dn[6:0]);
      end
    end

    // R3/R7: every acknowledge pattern against a full set of flags
    for (int p = 0; p < 128; p++) begin
      step("R4", 0, 32'h0, 7'h7F);
      step("R3", 1, 32'h00FF0000 | (p << 24), 7'h0);
      step("R9", 0, 32'h0, 7'h0);
    end

    // R4: completion wins over a same-edge acknowledge
    step("R7", 1, 32'h7F840000, 7'h0);
    step("R4", 1, 32'h04840000, 7'h04);
    step("R5", 0, 32'h0, 7'h0);
    // R4: enable written on the same edge does not gate that edge's completion
    step("R7", 1, 32'h7F000000, 7'h0);
    step("R4", 1, 32'h00FF0000, 7'h7F);

    // R5/R8: global enable turned on with flags already pending
    step("R4", 0, 32'h0, 7'h01);
    step("R7", 1, 32'h00010000, 7'h0);
    step("R5", 1, 32'h00810000, 7'h0);
    step("R8", 0, 32'h0, 7'h01);
    step("R9", 0, 32'h0, 7'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule